// File: doc/BRIEF.md
# Eight-bit multi-mode timer/counter

This block is an 8-bit counter that advances only on cycles where a count-enable strobe is high. The clock divider sits outside the block and produces that strobe. A 3-bit mode value picks one of four ways of running:

- a free-running up counter;
- an up counter that clears when it reaches compare value A;
- fast PWM, which counts from zero up to a ceiling and restarts at zero;
- phase-correct PWM, which counts up to a ceiling and back down.

In the PWM modes the ceiling (TOP) is either fixed at 0xFF or taken from compare value A, depending on the mode.

There are two compare channels, A and B. Each channel has a staging register that software writes and an active register that the counter is compared against. The mode decides when the staged value moves into the active register: at once, or on the count step taken while the counter sits at TOP. The block drives four kinds of output:

- a sticky overflow flag;
- one match line per channel;
- the count direction;
- strobes marking the counter at BOTTOM (zero) and at TOP.

Software writes the configuration, the compare values and the count itself through a small write port, and clears the flag through the same port.

A "step" is a cycle where `countEn` is high and the same cycle does not write the count register.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, the direction is up (`dirDown`=0), the mode is 0 and all compare registers hold 0x00.
- R2: The count changes only on steps or on a write to address 4. A count write in the same cycle as `countEn` loads the written value, and no step is taken in that cycle.
- R3: In mode 0, and in the reserved modes 4 and 6, each step adds one to the count, wrapping from 0xFF to 0x00.
- R4: In mode 2, TOP is the active compare A value. A step taken while the count equals TOP loads 0x00; any other step adds one.
- R5: In mode 3 (TOP fixed at 0xFF) and mode 7 (TOP equals active compare A), a step taken at TOP loads 0x00, and any other step adds one.
- R6: In mode 1 (TOP 0xFF) and mode 5 (TOP equals active compare A), the counter counts up to TOP. It reverses there (`dirDown`=1) and counts down to 0x00, where it reverses again (`dirDown`=0). When TOP is 0x00 it holds at zero. In every non-phase mode `dirDown` is 0 from the next cycle on.
- R7: `matchA` and `matchB` are high in every cycle where the count equals that channel's active compare value. `atBottom` is high when the count is 0x00. `atTop` is high when the count equals the current TOP.
- R8: In modes 0, 2, 4 and 6, a write to a compare register updates its active value on the same clock edge.
- R9: In modes 1, 3, 5 and 7, a written compare value is only staged. It becomes active on the next step taken while the count equals TOP.
- R10: The overflow flag is set as follows:
  - in modes 0, 2, 3, 4 and 6, by a step taken at 0xFF;
  - in modes 1 and 5, by a step taken at 0x00;
  - in mode 7, by a step taken at TOP.
- R11: The overflow flag stays set until a write to address 5 with bit 0 at one. A write there with bit 0 at zero leaves it unchanged, and a set in the same cycle wins over the clear.
- R12: The write addresses are:
  - 0: mode bits 1:0 in data bits 1:0; data bits 7:4 hold the output-mode fields for channels A and B, which this block accepts and does not use.
  - 1: mode bit 2 in data bit 3.
  - 2: compare A.
  - 3: compare B.
  - 4: count.
  - 5: flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Count-enable strobe, one step per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| count | output | 8 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| matchA | output | 1 | Count equals active compare A |
| matchB | output | 1 | Count equals active compare B |
| dirDown | output | 1 | Counter currently moving down |
| atBottom | output | 1 | Count is 0x00 |
| atTop | output | 1 | Count equals the current TOP |

## Verification
The assertions check the following on every cycle:
- the count stays put when no step and no count write occur;
- free-mode steps add one;
- fast-PWM steps at TOP return to zero;
- phase-correct down steps subtract one;
- the direction is up in non-phase modes;
- the flag stays set until a write-one clear.

Only the bench scenarios can show the timing of compare loads. That covers a staged value that must not act until the step at TOP, and an immediate value that must act at once. The same holds for the mode-dependent choice of overflow point and for the decoding of the two mode registers, since a property cannot know which value the software intended.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int NCH      = 2;
  localparam int ADR_CTLA = 0;
  localparam int ADR_CTLB = 1;
  localparam int ADR_CMPA = 2;
  localparam int ADR_CNT  = 4;
  localparam int ADR_FLG  = 5;
  localparam int MODE_HI_BIT = 3;

  typedef enum logic [1:0] {
    KIND_FREE,
    KIND_CLEAR,
    KIND_FAST,
    KIND_PHASE
  } tmrKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic toBottom;
    logic cmpLoad;
    logic cmpThrough;
    logic topFromA;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr8_datapath.sv
module tmr8_datapath
  import tmr8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strb,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [DW-1:0]       wrData,
  output logic [DW-1:0]       count,
  output logic                eqTop,
  output logic                eqBottom,
  output logic                eqMax,
  output logic [NCH-1:0]      matchVec
);

  localparam logic [DW-1:0] MAXV = '1;

  logic [DW-1:0]           cntQ;
  logic [NCH-1:0][DW-1:0]  actVec;
  logic [DW-1:0]           topVal;
  logic                    cntWr;

  assign cntWr = wrEn && (wrAddr == AW'(ADR_CNT));

  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (cntWr)         cntQ <= wrData;
    else if (strb.toBottom) cntQ <= '0;
    else if (strb.inc)      cntQ <= cntQ + 1'b1;
    else if (strb.dec)      cntQ <= cntQ - 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [DW-1:0] stageQ;
    logic [DW-1:0] actQ;
    logic          hit;

    assign hit = wrEn && (wrAddr == AW'(ADR_CMPA + ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ <= '0;
        actQ   <= '0;
      end else begin
        if (hit) stageQ <= wrData;
        if (strb.cmpThrough) actQ <= hit ? wrData : stageQ;
        else if (strb.cmpLoad) actQ <= stageQ;
      end
    end

    assign actVec[ch]   = actQ;
    assign matchVec[ch] = (cntQ == actQ);
  end

  assign topVal   = strb.topFromA ? actVec[0] : MAXV;
  assign eqTop    = (cntQ == topVal);
  assign eqBottom = (cntQ == '0);
  assign eqMax    = (cntQ == MAXV);
  assign count    = cntQ;

endmodule

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          countEn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          eqTop,
  input  logic          eqBottom,
  input  logic          eqMax,
  output tmrStrobe_t    strb,
  output logic          dirDown,
  output logic          ovfFlag,
  output logic [2:0]    modeNow
);

  logic [1:0] modeLoQ;
  logic       modeHiQ;
  logic       dirQ;
  logic       dirNext;
  logic       flagQ;
  logic       stepOk;
  logic       setFlag;
  logic       clrFlag;
  tmrKind_e   kind;

  assign modeNow = {modeHiQ, modeLoQ};
  assign stepOk  = countEn && !(wrEn && (wrAddr == AW'(ADR_CNT)));
  assign clrFlag = wrEn && (wrAddr == AW'(ADR_FLG)) && wrData[0];

  always_comb begin
    case (modeNow)
      3'd1, 3'd5: kind = KIND_PHASE;
      3'd2:       kind = KIND_CLEAR;
      3'd3, 3'd7: kind = KIND_FAST;
      default:    kind = KIND_FREE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.topFromA = (modeNow == 3'd2) || (modeNow == 3'd5) || (modeNow == 3'd7);
    dirNext       = 1'b0;
    case (kind)
      KIND_FREE: strb.inc = stepOk;
      KIND_CLEAR, KIND_FAST: begin
        strb.toBottom = stepOk && eqTop;
        strb.inc      = stepOk && !eqTop;
      end
      default: begin
        dirNext = dirQ;
        if (stepOk) begin
          if (!dirQ) begin
            if (eqTop && !eqBottom) begin
              strb.dec = 1'b1;
              dirNext  = 1'b1;
            end else if (!eqTop) begin
              strb.inc = 1'b1;
            end
          end else begin
            if (eqBottom && !eqTop) begin
              strb.inc = 1'b1;
              dirNext  = 1'b0;
            end else if (!eqBottom) begin
              strb.dec = 1'b1;
            end
          end
        end
      end
    endcase
    strb.cmpThrough = (kind == KIND_FREE) || (kind == KIND_CLEAR);
    strb.cmpLoad    = !strb.cmpThrough && stepOk && eqTop;
  end

  always_comb begin
    if (modeNow == 3'd7)          setFlag = stepOk && eqTop;
    else if (kind == KIND_PHASE)  setFlag = stepOk && eqBottom;
    else                          setFlag = stepOk && eqMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLoQ <= '0;
      modeHiQ <= 1'b0;
      dirQ    <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (wrEn && (wrAddr == AW'(ADR_CTLA))) modeLoQ <= wrData[1:0];
      if (wrEn && (wrAddr == AW'(ADR_CTLB))) modeHiQ <= wrData[MODE_HI_BIT];
      dirQ  <= dirNext;
      flagQ <= setFlag || (flagQ && !clrFlag);
    end
  end

  assign dirDown = dirQ;
  assign ovfFlag = flagQ;

endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
  import tmr8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          countEn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] count,
  output logic          ovfFlag,
  output logic          matchA,
  output logic          matchB,
  output logic          dirDown,
  output logic          atBottom,
  output logic          atTop
);

  tmrStrobe_t     strb;
  logic           eqTop;
  logic           eqBottom;
  logic           eqMax;
  logic [NCH-1:0] matchVec;
  logic [2:0]     modeNow;

  tmr8_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .countEn(countEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .eqTop(eqTop), .eqBottom(eqBottom), .eqMax(eqMax),
    .strb(strb), .dirDown(dirDown), .ovfFlag(ovfFlag), .modeNow(modeNow)
  );

  tmr8_datapath #(.DW(DW), .AW(AW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .eqTop(eqTop), .eqBottom(eqBottom), .eqMax(eqMax),
    .matchVec(matchVec)
  );

  assign matchA   = matchVec[0];
  assign matchB   = matchVec[1];
  assign atBottom = eqBottom;
  assign atTop    = eqTop;

endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker
  import tmr8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          countEn,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] count,
  input logic          ovfFlag,
  input logic          dirDown,
  input logic          atTop,
  input logic          atBottom,
  input logic [2:0]    modeNow
);

  logic cntWr, stepOk, isFree, isFast, isPhase, clrReq;

  assign cntWr   = wrEn && (wrAddr == AW'(ADR_CNT));
  assign stepOk  = countEn && !cntWr;
  assign isFree  = (modeNow == 3'd0) || (modeNow == 3'd4) || (modeNow == 3'd6);
  assign isFast  = (modeNow == 3'd3) || (modeNow == 3'd7);
  assign isPhase = (modeNow == 3'd1) || (modeNow == 3'd5);
  assign clrReq  = wrEn && (wrAddr == AW'(ADR_FLG)) && wrData[0];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !cntWr) |=> $stable(count));

  assert_free_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && isFree) |=> (count == DW'($past(count) + 1'b1)));

  assert_fast_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && isFast && atTop) |=> (count == '0));

  assert_phase_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && isPhase && dirDown && !atBottom) |=> (count == DW'($past(count) - 1'b1)));

  assert_dir_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!isPhase) |=> !dirDown);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrReq) |=> ovfFlag);

endmodule

bind tmr8_multimode tmr8_checker #(.DW(DW), .AW(AW)) u_check (
  .clk(clk), .rstN(rstN), .countEn(countEn),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .count(count), .ovfFlag(ovfFlag), .dirDown(dirDown),
  .atTop(atTop), .atBottom(atBottom), .modeNow(modeNow)
);

// File: tb/test_tmr8_multimode.sv
`timescale 1ns/1ps
module test_tmr8_multimode;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] count;
  logic       ovfFlag, matchA, matchB, dirDown, atBottom, atTop;

  tmr8_multimode i_tmr8_multimode (
    .clk(clk), .rstN(rstN), .countEn(countEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .ovfFlag(ovfFlag), .matchA(matchA), .matchB(matchB),
    .dirDown(dirDown), .atBottom(atBottom), .atTop(atTop)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [7:0] mCnt = '0, mStA = '0, mStB = '0, mActA = '0, mActB = '0;
  logic       mFlag = 1'b0, mDir = 1'b0, mHi = 1'b0;
  logic [1:0] mLo = '0;

  function automatic int kindOf(input logic [2:0] m);
    if (m == 3'd1 || m == 3'd5) return 3;
    if (m == 3'd3 || m == 3'd7) return 2;
    if (m == 3'd2) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] topOf(input logic [2:0] m, input logic [7:0] a);
    return (m == 3'd2 || m == 3'd5 || m == 3'd7) ? a : 8'hFF;
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    case (kindOf(m))
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic modelStep(input logic ce, input logic we, input logic [2:0] a, input logic [7:0] d);
    logic [2:0] md;
    logic [7:0] top, nCnt, nActA, nActB;
    logic       nDir, setF, cw, step, imm;
    int         k;
    md   = {mHi, mLo};
    k    = kindOf(md);
    top  = topOf(md, mActA);
    cw   = we && (a == 3'd4);
    step = ce && !cw;
    nCnt = mCnt;
    nDir = 1'b0;
    if (step) begin
      if (k == 0) nCnt = mCnt + 8'd1;
      else if (k == 1 || k == 2) nCnt = (mCnt == top) ? 8'd0 : mCnt + 8'd1;
    end
    if (k == 3) begin
      nDir = mDir;
      if (step) begin
        if (!mDir) begin
          if (mCnt == top && top != 8'd0) begin nCnt = mCnt - 8'd1; nDir = 1'b1; end
          else if (mCnt != top) nCnt = mCnt + 8'd1;
        end else begin
          if (mCnt == 8'd0 && top != 8'd0) begin nCnt = 8'd1; nDir = 1'b0; end
          else if (mCnt != 8'd0) nCnt = mCnt - 8'd1;
        end
      end
    end
    if (md == 3'd7)  setF = step && (mCnt == top);
    else if (k == 3) setF = step && (mCnt == 8'd0);
    else             setF = step && (mCnt == 8'hFF);
    imm   = (k == 0 || k == 1);
    nActA = mActA;
    nActB = mActB;
    if (imm) begin
      nActA = (we && a == 3'd2) ? d : mStA;
      nActB = (we && a == 3'd3) ? d : mStB;
    end else if (step && mCnt == top) begin
      nActA = mStA;
      nActB = mStB;
    end
    mFlag = setF || (mFlag && !(we && a == 3'd5 && d[0]));
    mCnt  = cw ? d : nCnt;
    mDir  = nDir;
    mActA = nActA;
    mActB = nActB;
    if (we && a == 3'd2) mStA = d;
    if (we && a == 3'd3) mStB = d;
    if (we && a == 3'd0) mLo = d[1:0];
    if (we && a == 3'd1) mHi = d[3];
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkModel();
    string t;
    t = tagOf({mHi, mLo});
    check({t, " count"}, count, mCnt);
    check({t, " dir"}, {7'd0, dirDown}, {7'd0, mDir});
    check("R10 flag", {7'd0, ovfFlag}, {7'd0, mFlag});
    check("R7 matchA", {7'd0, matchA}, {7'd0, mCnt == mActA});
    check("R7 matchB", {7'd0, matchB}, {7'd0, mCnt == mActB});
    check("R7 atTop", {7'd0, atTop}, {7'd0, mCnt == topOf({mHi, mLo}, mActA)});
    check("R7 atBottom", {7'd0, atBottom}, {7'd0, mCnt == 8'd0});
  endtask

  task automatic cyc(input logic ce, input logic we, input logic [2:0] a, input logic [7:0] d);
    countEn = ce; wrEn = we; wrAddr = a; wrData = d;
    @(posedge clk);
    modelStep(ce, we, a, d);
    @(negedge clk);
    countEn = 1'b0; wrEn = 1'b0;
    checkModel();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 count", count, 8'd0);
    check("R1 flag", {7'd0, ovfFlag}, 8'd0);
    check("R1 dir", {7'd0, dirDown}, 8'd0);
    check("R1 matchB", {7'd0, matchB}, 8'd1);
    // R2 no steps while the enable is low
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 3'd0, 8'd0);
    check("R2 idle", count, 8'd0);
    cyc(1'b1, 1'b1, 3'd4, 8'h40);
    check("R2 write wins", count, 8'h40);
    // R3 wrap and R10 overflow at MAX
    wr(3'd4, 8'hFE);
    steps(1);
    check("R3 step", count, 8'hFF);
    steps(1);
    check("R3 wrap", count, 8'h00);
    check("R10 max", {7'd0, ovfFlag}, 8'd1);
    // R11 clear semantics
    wr(3'd5, 8'h00);
    check("R11 no clear", {7'd0, ovfFlag}, 8'd1);
    wr(3'd5, 8'h01);
    check("R11 clear", {7'd0, ovfFlag}, 8'd0);
    // R4 / R8 clear on match with immediate compare
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h03);
    wr(3'd4, 8'h00);
    steps(3);
    check("R8 immediate matchA", {7'd0, matchA}, 8'd1);
    check("R4 atTop", {7'd0, atTop}, 8'd1);
    steps(1);
    check("R4 clear", count, 8'h00);
    check("R10 no flag", {7'd0, ovfFlag}, 8'd0);
    // R12 upper control bits ignored
    wr(3'd0, 8'hF0);
    wr(3'd4, 8'h03);
    steps(1);
    check("R12 mode0", count, 8'h04);
    // R9 / R5 fast PWM with TOP from A, deferred update
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h06);
    wr(3'd4, 8'h01);
    steps(1);
    check("R9 staged", {7'd0, matchA}, 8'd0);
    steps(1);
    check("R9 old top", {7'd0, atTop}, 8'd1);
    steps(1);
    check("R5 restart", count, 8'h00);
    check("R10 top", {7'd0, ovfFlag}, 8'd1);
    steps(6);
    check("R9 new top", {7'd0, atTop}, 8'd1);
    steps(1);
    check("R5 restart2", count, 8'h00);
    // R6 phase correct, TOP 0xFF
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd5, 8'h01);
    wr(3'd4, 8'hFE);
    steps(1);
    check("R6 up", count, 8'hFF);
    steps(1);
    check("R6 reverse", count, 8'hFE);
    check("R6 dir", {7'd0, dirDown}, 8'd1);
    wr(3'd4, 8'h01);
    steps(1);
    check("R6 bottom", count, 8'h00);
    check("R10 not yet", {7'd0, ovfFlag}, 8'd0);
    steps(1);
    check("R6 up again", count, 8'h01);
    check("R10 bottom", {7'd0, ovfFlag}, 8'd1);
    // R9 phase correct, TOP from A
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h04);
    steps(5);
    check("R9 pc old top", {7'd0, atTop}, 8'd1);
    steps(1);
    check("R6 pc down", count, 8'h05);
    steps(6);
    check("R6 pc up", count, 8'h01);
    steps(3);
    check("R9 pc new top", {7'd0, atTop}, 8'd1);
    steps(1);
    check("R6 pc reverse", count, 8'h03);
    // random traffic, every cycle compared to the reference
    for (int blk = 0; blk < 12; blk++) begin
      logic [2:0] md;
      md = 3'($urandom % 8);
      wr(3'd0, {4'($urandom), 2'b00, md[1:0]});
      wr(3'd1, {4'd0, md[2], 3'd0});
      for (int i = 0; i < 300; i++) begin
        int r;
        r = int'($urandom % 100);
        if (r < 5)       wr(3'd2, 8'($urandom));
        else if (r < 9)  wr(3'd3, 8'($urandom));
        else if (r < 11) wr(3'd4, 8'($urandom));
        else if (r < 14) wr(3'd5, 8'($urandom));
        else if (r < 16) cyc(1'b1, 1'b1, 3'd4, 8'($urandom));
        else             cyc(r < 85, 1'b0, 3'd0, 8'd0);
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule